// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath that shares one memory and one ALU across every step of an instruction. It watches the 6-bit opcode held in the datapath's instruction register and walks a 4-bit state register through instruction fetch, register decode and the execution steps of each instruction class. In every state it drives the datapath's control points: the PC and instruction-register write enables, the memory address source, memory read and write, the ALU operand selects and operation class, and the register-file write controls.

Four instruction classes are sequenced: word load, word store, register-to-register arithmetic and branch-on-equal. Load needs five cycles, store and arithmetic need four, and branch needs three. An opcode outside these classes ends the instruction after decode. The state number is brought out so that a datapath model or a checker can follow the sequence. Next state and outputs depend only on the current state and the opcode, so the whole unit could equally be built as a lookup table.

Top module: `mcyc_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 0 (fetch) on that edge, whatever the opcode and the current state.
- R2: State 0 drives `mem_re`=1, `ir_we`=1, `pc_we`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=1, `alu_op`=0, `pc_sel`=0, and always moves to state 1.
- R3: State 1 drives `alu_a_sel`=0, `alu_b_sel`=3, `alu_op`=0 and moves on opcode 0x23 or 0x2B to state 2, on 0x00 to state 6, on 0x04 to state 8, and on any other opcode to state 0.
- R4: State 2 drives `alu_a_sel`=1, `alu_b_sel`=2, `alu_op`=0 and moves to state 3 on opcode 0x23, to state 5 on 0x2B, and to state 0 on any other opcode.
- R5: Load completes through state 3 (`mem_re`=1, `addr_sel`=1, then state 4) and state 4 (`rf_we`=1, `wb_sel`=1, `rf_dst_sel`=0, then state 0).
- R6: State 5 drives `mem_we`=1 and `addr_sel`=1 and moves to state 0.
- R7: State 6 drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=2 and moves to state 7; state 7 drives `rf_we`=1, `rf_dst_sel`=1, `wb_sel`=0 and moves to state 0.
- R8: State 8 drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1, `pc_we_cond`=1, `pc_sel`=1 and moves to state 0.
- R9: Every control output not named for a state in R2 to R8 is 0 in that state; `mem_re` and `mem_we` are never high together.
- R10: The opcode has no effect on the next state in any state other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current state number |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write when the ALU zero flag is set |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register write |
| wb_sel | output | 1 | Register write data: 0 = ALU result register, 1 = memory data register |
| pc_sel | output | 1 | PC source: 0 = ALU output, 1 = ALU result register |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 function field |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 0 = register B, 1 = constant 4, 2 = sign-extended immediate, 3 = immediate shifted left by 2 |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register field: 0 = rt, 1 = rd |

## Verification
Directed runs hold each class's opcode steady through a whole instruction, which separates the four sequences by their length and the states they visit. An unlisted opcode at decode shows the early return to fetch. Random runs change the opcode every cycle from a pool mixing the four class opcodes with arbitrary values. That separates a unit that samples the opcode only at decode and address calculation from one that reacts to it elsewhere. It also reaches state 2 with an opcode that is neither load nor store. Rare random resets, and one directed reset in the middle of a load, show that reset wins over any state.

// File: rtl/mcyc_ctrl_pkg.sv
`timescale 1ns/1ps
package mcyc_ctrl_pkg;

  localparam int OP_W  = 6;
  localparam int ST_W  = 4;
  localparam int SEL_W = 2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDMEM  = 4'd3,
    S_LDWB   = 4'd4,
    S_STMEM  = 4'd5,
    S_REXE   = 4'd6,
    S_RWB    = 4'd7,
    S_BR     = 4'd8
  } st_e;

  typedef enum logic [2:0] {
    K_RTYPE,
    K_LOAD,
    K_STORE,
    K_BRANCH,
    K_OTHER
  } cls_e;

  typedef struct packed {
    logic             pc_we;
    logic             pc_we_cond;
    logic             addr_sel;
    logic             mem_re;
    logic             mem_we;
    logic             ir_we;
    logic             wb_sel;
    logic             pc_sel;
    logic [SEL_W-1:0] alu_op;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic             rf_we;
    logic             rf_dst_sel;
  } ctrl_t;

endpackage

// File: rtl/mcyc_ctrl_classify.sv
`timescale 1ns/1ps
module mcyc_ctrl_classify
  import mcyc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output cls_e            cls
);

  function automatic cls_e classify(input logic [OP_W-1:0] op);
    case (op)
      OP_RTYPE: return K_RTYPE;
      OP_LOAD:  return K_LOAD;
      OP_STORE: return K_STORE;
      OP_BEQ:   return K_BRANCH;
      default:  return K_OTHER;
    endcase
  endfunction

  assign cls = classify(opcode);

endmodule

// File: rtl/mcyc_ctrl_next.sv
`timescale 1ns/1ps
module mcyc_ctrl_next
  import mcyc_ctrl_pkg::*;
(
  input  st_e  cur,
  input  cls_e cls,
  output st_e  nxt
);

  function automatic st_e step(input st_e s, input cls_e k);
    case (s)
      S_FETCH:  return S_DECODE;
      S_DECODE: begin
        case (k)
          K_LOAD, K_STORE: return S_ADDR;
          K_RTYPE:         return S_REXE;
          K_BRANCH:        return S_BR;
          default:         return S_FETCH;
        endcase
      end
      S_ADDR: begin
        case (k)
          K_LOAD:  return S_LDMEM;
          K_STORE: return S_STMEM;
          default: return S_FETCH;
        endcase
      end
      S_LDMEM:  return S_LDWB;
      S_REXE:   return S_RWB;
      default:  return S_FETCH;
    endcase
  endfunction

  assign nxt = step(cur, cls);

endmodule

// File: rtl/mcyc_ctrl_outputs.sv
`timescale 1ns/1ps
module mcyc_ctrl_outputs
  import mcyc_ctrl_pkg::*;
(
  input  st_e   cur,
  output ctrl_t ctl
);

  function automatic ctrl_t decode_state(input st_e s);
    ctrl_t c;
    c = '0;
    case (s)
      S_FETCH: begin
        c.mem_re    = 1'b1;
        c.ir_we     = 1'b1;
        c.pc_we     = 1'b1;
        c.alu_b_sel = 2'd1;
      end
      S_DECODE: c.alu_b_sel = 2'd3;
      S_ADDR: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = 2'd2;
      end
      S_LDMEM: begin
        c.mem_re   = 1'b1;
        c.addr_sel = 1'b1;
      end
      S_LDWB: begin
        c.rf_we  = 1'b1;
        c.wb_sel = 1'b1;
      end
      S_STMEM: begin
        c.mem_we   = 1'b1;
        c.addr_sel = 1'b1;
      end
      S_REXE: begin
        c.alu_a_sel = 1'b1;
        c.alu_op    = 2'd2;
      end
      S_RWB: begin
        c.rf_we      = 1'b1;
        c.rf_dst_sel = 1'b1;
      end
      S_BR: begin
        c.alu_a_sel  = 1'b1;
        c.alu_op     = 2'd1;
        c.pc_we_cond = 1'b1;
        c.pc_sel     = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  assign ctl = decode_state(cur);

endmodule

// File: rtl/mcyc_ctrl.sv
`timescale 1ns/1ps
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic [ST_W-1:0]  state_o,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic             addr_sel,
  output logic             mem_re,
  output logic             mem_we,
  output logic             ir_we,
  output logic             wb_sel,
  output logic             pc_sel,
  output logic [SEL_W-1:0] alu_op,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic             rf_we,
  output logic             rf_dst_sel
);

  st_e   state_q;
  st_e   state_d;
  cls_e  op_cls;
  ctrl_t ctl;

  mcyc_ctrl_classify u_cls (.opcode(opcode), .cls(op_cls));
  mcyc_ctrl_next     u_nxt (.cur(state_q), .cls(op_cls), .nxt(state_d));
  mcyc_ctrl_outputs  u_out (.cur(state_q), .ctl(ctl));

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_d;
  end

  assign state_o    = state_q;
  assign pc_we      = ctl.pc_we;
  assign pc_we_cond = ctl.pc_we_cond;
  assign addr_sel   = ctl.addr_sel;
  assign mem_re     = ctl.mem_re;
  assign mem_we     = ctl.mem_we;
  assign ir_we      = ctl.ir_we;
  assign wb_sel     = ctl.wb_sel;
  assign pc_sel     = ctl.pc_sel;
  assign alu_op     = ctl.alu_op;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign rf_we      = ctl.rf_we;
  assign rf_dst_sel = ctl.rf_dst_sel;

  // Named events for the checks below
  logic in_fetch, in_decode, in_ldmem, in_rexe, op_unknown, rst_q;
  assign in_fetch   = (state_q == S_FETCH);
  assign in_decode  = (state_q == S_DECODE);
  assign in_ldmem   = (state_q == S_LDMEM);
  assign in_rexe    = (state_q == S_REXE);
  assign op_unknown = (op_cls == K_OTHER);

  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(negedge clk) begin
    if (rst_q === 1'b1) begin
      rst_state_chk: assert (state_o == 4'd0);
    end
  end

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    in_fetch |=> (state_o == 4'd1));

  // R3
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_decode && op_unknown) |=> (state_o == 4'd0));

  // R5
  ld_seq_chk: assert property (@(posedge clk) disable iff (rst)
    in_ldmem |=> (state_o == 4'd4));

  // R7
  r_seq_chk: assert property (@(posedge clk) disable iff (rst)
    in_rexe |=> (state_o == 4'd7));

  // R8
  br_src_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we_cond |-> (pc_sel && !pc_we && state_o == 4'd8));

  // R9
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

endmodule

// File: tb/sim_mcyc_ctrl.sv
`timescale 1ns/1ps
module sim_mcyc_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [3:0] state_o;
  logic       pc_we, pc_we_cond, addr_sel, mem_re, mem_we, ir_we, wb_sel, pc_sel;
  logic [1:0] alu_op, alu_b_sel;
  logic       alu_a_sel, rf_we, rf_dst_sel;

  int n_chk = 0;
  int n_err = 0;
  logic [3:0] exp_s  = 4'd0;
  logic [3:0] prev_s = 4'd0;
  logic       prev_rst = 1'b1;
  logic       prev_op_used = 1'b0;
  logic       armed = 1'b0;

  always #2.5 clk = ~clk;

  mcyc_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .addr_sel(addr_sel),
    .mem_re(mem_re), .mem_we(mem_we), .ir_we(ir_we), .wb_sel(wb_sel),
    .pc_sel(pc_sel), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_we(rf_we), .rf_dst_sel(rf_dst_sel)
  );

  wire [14:0] act_ctl = {pc_we, pc_we_cond, addr_sel, mem_re, mem_we, ir_we,
                         wb_sel, pc_sel, alu_op, alu_a_sel, alu_b_sel,
                         rf_we, rf_dst_sel};

  // Independent model of the sequence
  function automatic logic [3:0] model_next(input logic [3:0] s, input logic [5:0] op);
    if (s == 4'd0) return 4'd1;
    if (s == 4'd1) begin
      if (op == 6'h23 || op == 6'h2B) return 4'd2;
      if (op == 6'h00) return 4'd6;
      if (op == 6'h04) return 4'd8;
      return 4'd0;
    end
    if (s == 4'd2) return (op == 6'h23) ? 4'd3 : (op == 6'h2B) ? 4'd5 : 4'd0;
    if (s == 4'd3) return 4'd4;
    if (s == 4'd6) return 4'd7;
    return 4'd0;
  endfunction

  // Fields: pc_we pc_we_cond addr mem_re mem_we ir_we wb pc_sel op[2] a b[2] rf_we dst
  function automatic logic [14:0] model_ctl(input logic [3:0] s);
    logic pcw = 0, pcc = 0, adr = 0, mr = 0, mw = 0, irw = 0, wb = 0, ps = 0;
    logic [1:0] op = 0, b = 0;
    logic a = 0, rw = 0, dst = 0;
    unique case (s)
      4'd0: begin mr = 1; irw = 1; pcw = 1; b = 2'd1; end
      4'd1: b = 2'd3;
      4'd2: begin a = 1; b = 2'd2; end
      4'd3: begin mr = 1; adr = 1; end
      4'd4: begin rw = 1; wb = 1; end
      4'd5: begin mw = 1; adr = 1; end
      4'd6: begin a = 1; op = 2'd2; end
      4'd7: begin rw = 1; dst = 1; end
      4'd8: begin a = 1; op = 2'd1; pcc = 1; ps = 1; end
      default: ;
    endcase
    return {pcw, pcc, adr, mr, mw, irw, wb, ps, op, a, b, rw, dst};
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  // One cycle: check present outputs, then apply inputs for the next edge
  task automatic cycle(input logic r, input logic [5:0] op);
    @(negedge clk);
    if (armed) begin
      if (prev_rst)
        check(state_o == exp_s, "R1", {11'd0, state_o}, {11'd0, exp_s});
      else if (prev_op_used)
        check(state_o == exp_s, req_of(prev_s), {11'd0, state_o}, {11'd0, exp_s});
      else  // R10: opcode ignored outside states 1 and 2
        check(state_o == exp_s, {req_of(prev_s), "/R10"}, {11'd0, state_o}, {11'd0, exp_s});
      check(act_ctl == model_ctl(exp_s), {req_of(exp_s), "/R9"}, act_ctl, model_ctl(exp_s));
      check(!(mem_re && mem_we), "R9", act_ctl, 15'd0);
    end
    rst = r;
    opcode = op;
    prev_s = exp_s;
    prev_rst = r;
    prev_op_used = (exp_s == 4'd1 || exp_s == 4'd2);
    exp_s = r ? 4'd0 : model_next(exp_s, op);
    armed = 1'b1;
  endtask

  task automatic run_instr(input logic [5:0] op, input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, op);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cycle(1'b1, 6'h3F);
    cycle(1'b1, 6'h23);  // R1 reset state checked next
    cycle(1'b0, 6'h00);
    // Directed: whole instructions per class
    run_instr(6'h23, 5);   // R5 load
    run_instr(6'h2B, 4);   // R6 store
    run_instr(6'h00, 4);   // R7 R-format
    run_instr(6'h04, 3);   // R8 branch
    run_instr(6'h3F, 2);   // R3 unknown opcode
    run_instr(6'h23, 3);   // into load memory read
    cycle(1'b1, 6'h23);    // R1 reset mid-instruction
    cycle(1'b0, 6'h23);
    run_instr(6'h23, 6);
    // Random: opcode may change every cycle (R10), rare resets
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1: op = 6'h23;
        2, 3: op = 6'h2B;
        4, 5: op = 6'h00;
        6, 7: op = 6'h04;
        default: op = 6'($urandom);
      endcase
      cycle(($urandom_range(0, 199) == 0), op);
    end
    cycle(1'b0, 6'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule